// File: doc/BRIEF.md
# Daisy-Chained Codec Serial Port

This block is the serial port of one codec that sits in a daisy chain of identical codecs. All of the codecs share one frame sync from the host. Each stage takes in 16-bit words on a serial input that is qualified by an input frame sync. It sends words out on a serial output with its own output frame sync. In a chain, one stage's output pair drives the next stage's input pair. The whole design runs on the bit clock.

After reset the port is in program mode. Here a received control word is handled in one of two ways:
- If its address field is zero, the word writes one of eight 8-bit control registers.
- If the address field is nonzero, the field is reduced by one and the word is passed down the chain.

Plain words are passed on unchanged.

Setting the mode bit in register 0 switches the port to data mode. In data mode, addressing works by counting frames: the port counts received words. The word that brings the count up to the programmed chain length is latched as the DAC word, and the count starts again. Words before that one are forwarded. Separately, each pulse on the sample strobe loads the ADC word and sends it out. A sample launch and a forward can be due at the same time. They are queued in two slots, and the sample word always goes first.

Top module: `daisy_codec_port`

## Requirements
- R1: After reset the outputs are as follows: `sdofs_o` and `dac_upd_o` are low, `data_mode_o` is low (program mode), all control registers read zero (which means chain length one), and `dac_word_o` is zero.
- R2: A word is framed in one of two ways.
  - Receive: the input frame sync is sampled high one clock before the first data bit, and 16 data bits follow on consecutive clocks, MSB first.
  - Transmit: `sdofs_o` is high for exactly one cycle, and the 16 bits follow on `sdo_o` on the next 16 cycles, MSB first.
- R3: In program mode, a control word is one with bit 15 = 1. If its address bits 13:11 are zero, it writes data bits 7:0 into the register selected by bits 10:8. Register n appears at `ctrl_regs_o[8n+7:8n]`. The word is not forwarded.
- R4: In program mode, a control word with a nonzero address is forwarded with bits 13:11 reduced by one and all other bits unchanged.
- R5: In program mode, a word with bit 15 = 0 is forwarded unchanged, whatever its bits 13:11 hold.
- R6: When the transmitter is idle, a forwarded word raises `sdofs_o` in the cycle after the clock edge that samples its last data bit.
- R7: A pulse on `sample_i` captures `adc_word_i`. When the transmitter is idle, `sdofs_o` rises in the next cycle and that word is sent.
- R8: If a sample launch and a forward are due at the same edge, the ADC word is sent first. The forwarded word's `sdofs_o` follows 17 cycles after the ADC word's `sdofs_o`.
- R9: Register 0 holds the mode bit and the chain length.
  - Bit 7 is the mode bit. Writing 1 to it enters data mode, and `data_mode_o` then stays high until reset.
  - Bits 2:0 hold the chain length minus one.
  - In data mode no control register changes.
- R10: In data mode, every received word advances a frame counter. The word that makes the count equal to the chain length is placed on `dac_word_o` and is not forwarded. `dac_upd_o` pulses for one cycle, and the counter returns to zero.
- R11: In data mode, words that arrive before the count is reached are forwarded unchanged, even when bit 15 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdi_i | input | 1 | Serial data in |
| sdifs_i | input | 1 | Input frame sync |
| sample_i | input | 1 | Sample event strobe |
| adc_word_i | input | 16 | ADC word captured on a sample event |
| sdo_o | output | 1 | Serial data out |
| sdofs_o | output | 1 | Output frame sync |
| dac_word_o | output | 16 | Latched DAC word |
| dac_upd_o | output | 1 | One-cycle pulse when the DAC word is updated |
| data_mode_o | output | 1 | High in data mode |
| ctrl_regs_o | output | 64 | Eight 8-bit control registers, register n at bits 8n+7:8n |

## Verification
A sample strobe and the end of a received word can land on the same clock edge. At that edge both the ADC launch and a forward want the transmitter. The bench provokes this by raising `sample_i` in the same cycle as the last data bit of a word that must be forwarded. It then checks three things on the recovered output stream: the ADC word comes first, the forwarded word follows intact, and the two output frame syncs are exactly 17 cycles apart. Randomly drawn control, addressed and plain words, and data-mode words, are checked against a bench model of the register file and the frame counter.

// File: rtl/dcsp_pkg.sv
package dcsp_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned LEN_W   = 3;
  localparam int unsigned NREG    = 1 << SEL_W;
  localparam int unsigned CNT_W   = $clog2(WORD_W + 1);
  localparam int unsigned FLAG_B  = WORD_W - 1;
  localparam int unsigned SEL_LSB = DATA_W;
  localparam int unsigned ADR_LSB = DATA_W + SEL_W;
  localparam int unsigned MODE_B  = DATA_W - 1;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dcsp_rx.sv
module dcsp_rx
  import dcsp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fs_i,
  input  logic  sd_i,
  output logic  done_o,
  output word_t word_o
);
  logic [CNT_W-1:0]  left_q;
  logic [WORD_W-2:0] sr_q;

  assign word_o = {sr_q, sd_i};
  assign done_o = (left_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      sr_q   <= '0;
    end else if (left_q != '0) begin
      sr_q   <= word_o[WORD_W-2:0];
      left_q <= left_q - CNT_W'(1);
    end else if (fs_i) begin
      left_q <= CNT_W'(WORD_W);
    end
  end
endmodule

// File: rtl/dcsp_tx.sv
module dcsp_tx
  import dcsp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  samp_i,
  input  word_t samp_word_i,
  input  logic  fwd_i,
  input  word_t fwd_word_i,
  output logic  fs_o,
  output logic  sd_o
);
  logic [CNT_W-1:0] left_q;
  word_t sr_q, s_w_q, f_w_q;
  logic  s_v_q, f_v_q, fs_q, sd_q;
  logic  eff_s_v, eff_f_v, idle, go_s, go_f;
  word_t eff_s_w, eff_f_w;

  // pending slots merged with same-cycle requests
  assign eff_s_v = s_v_q | samp_i;
  assign eff_s_w = samp_i ? samp_word_i : s_w_q;
  assign eff_f_v = f_v_q | fwd_i;
  assign eff_f_w = fwd_i ? fwd_word_i : f_w_q;
  assign idle    = (left_q == '0) && !fs_q;
  assign go_s    = idle && eff_s_v;
  assign go_f    = idle && !eff_s_v && eff_f_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_v_q  <= 1'b0;
      f_v_q  <= 1'b0;
      s_w_q  <= '0;
      f_w_q  <= '0;
      sr_q   <= '0;
      left_q <= '0;
      fs_q   <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      s_v_q <= eff_s_v && !go_s;
      f_v_q <= eff_f_v && !go_f;
      s_w_q <= eff_s_w;
      f_w_q <= eff_f_w;
      if (go_s || go_f) begin
        fs_q   <= 1'b1;
        sr_q   <= go_s ? eff_s_w : eff_f_w;
        left_q <= CNT_W'(WORD_W);
      end else begin
        fs_q <= 1'b0;
        if (left_q != '0) begin
          sd_q   <= sr_q[WORD_W-1];
          sr_q   <= {sr_q[WORD_W-2:0], 1'b0};
          left_q <= left_q - CNT_W'(1);
        end else begin
          sd_q <= 1'b0;
        end
      end
    end
  end

  assign fs_o = fs_q;
  assign sd_o = sd_q;
endmodule

// File: rtl/dcsp_ctrl.sv
module dcsp_ctrl
  import dcsp_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   done_i,
  input  word_t                  word_i,
  output logic                   fwd_o,
  output word_t                  fwd_word_o,
  output logic                   data_mode_o,
  output word_t                  dac_o,
  output logic                   dac_upd_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] regs_q [NREG];
  logic [LEN_W:0]    cnt_q, cnt_n, len;
  logic [ADDR_W-1:0] addr;
  logic [SEL_W-1:0]  sel;
  logic              mode, wr, lat, upd_q;
  word_t             dac_q;

  assign mode = regs_q[0][MODE_B];
  assign len  = {1'b0, regs_q[0][LEN_W-1:0]} + (LEN_W+1)'(1);
  assign addr = word_i[ADR_LSB +: ADDR_W];
  assign sel  = word_i[SEL_LSB +: SEL_W];

  always_comb begin
    fwd_o      = 1'b0;
    fwd_word_o = word_i;
    wr         = 1'b0;
    lat        = 1'b0;
    cnt_n      = cnt_q + (LEN_W+1)'(1);
    if (done_i) begin
      if (!mode) begin
        if (word_i[FLAG_B] && addr == '0) begin
          wr = 1'b1;
        end else begin
          fwd_o = 1'b1;
          if (word_i[FLAG_B]) fwd_word_o[ADR_LSB +: ADDR_W] = addr - ADDR_W'(1);
        end
      end else if (cnt_n == len) begin
        lat = 1'b1;
      end else begin
        fwd_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NREG); i++) regs_q[i] <= '0;
      cnt_q <= '0;
      dac_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= lat;
      if (wr) regs_q[sel] <= word_i[DATA_W-1:0];
      if (lat) dac_q <= word_i;
      if (done_i && mode) cnt_q <= lat ? '0 : cnt_n;
    end
  end

  for (genvar g = 0; g < int'(NREG); g++) begin : g_regs
    assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];
  end

  assign data_mode_o = mode;
  assign dac_o       = dac_q;
  assign dac_upd_o   = upd_q;
endmodule

// File: rtl/daisy_codec_port.sv
module daisy_codec_port
  import dcsp_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sdi_i,
  input  logic                   sdifs_i,
  input  logic                   sample_i,
  input  logic [WORD_W-1:0]      adc_word_i,
  output logic                   sdo_o,
  output logic                   sdofs_o,
  output logic [WORD_W-1:0]      dac_word_o,
  output logic                   dac_upd_o,
  output logic                   data_mode_o,
  output logic [NREG*DATA_W-1:0] ctrl_regs_o
);
  logic  rx_done, fwd;
  word_t rx_word, fwd_word;

  dcsp_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fs_i   (sdifs_i),
    .sd_i   (sdi_i),
    .done_o (rx_done),
    .word_o (rx_word)
  );

  dcsp_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (rx_done),
    .word_i      (rx_word),
    .fwd_o       (fwd),
    .fwd_word_o  (fwd_word),
    .data_mode_o (data_mode_o),
    .dac_o       (dac_word_o),
    .dac_upd_o   (dac_upd_o),
    .regs_o      (ctrl_regs_o)
  );

  dcsp_tx u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .samp_i      (sample_i),
    .samp_word_i (adc_word_i),
    .fwd_i       (fwd),
    .fwd_word_i  (fwd_word),
    .fs_o        (sdofs_o),
    .sd_o        (sdo_o)
  );
endmodule

// File: rtl/dcsp_chk.sv
module dcsp_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sdofs_o,
  input logic [15:0] dac_word_o,
  input logic        dac_upd_o,
  input logic        data_mode_o,
  input logic [63:0] ctrl_regs_o
);
  // R2
  single_fs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdofs_o |=> !sdofs_o);
  // R9
  mode_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_mode_o |=> data_mode_o);
  // R9
  regs_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_mode_o && $past(data_mode_o)) |-> $stable(ctrl_regs_o));
  // R10
  upd_in_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_upd_o |-> data_mode_o);
  // R10
  dac_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_upd_o |-> $stable(dac_word_o));
endmodule

bind daisy_codec_port dcsp_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sdofs_o     (sdofs_o),
  .dac_word_o  (dac_word_o),
  .dac_upd_o   (dac_upd_o),
  .data_mode_o (data_mode_o),
  .ctrl_regs_o (ctrl_regs_o)
);

// File: tb/tb_daisy_codec_port.sv
module tb_daisy_codec_port;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        sdi_i = 1'b0, sdifs_i = 1'b0, sample_i = 1'b0;
  logic [15:0] adc_word_i = '0;
  logic        sdo_o, sdofs_o, dac_upd_o, data_mode_o;
  logic [15:0] dac_word_o;
  logic [63:0] ctrl_regs_o;

  int vectors = 0, miscompares = 0, cyc = 0;
  logic [15:0] out_q[$];
  int          stamp_q[$];
  int          mon_left = 0, mon_stamp = 0;
  logic [15:0] mon_sr = '0;
  logic [7:0]  mregs[8];

  always #5 clk_i = ~clk_i;

  daisy_codec_port dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_regs();
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = mregs[i];
    return r;
  endfunction

  // output frame monitor (R2 framing)
  always @(negedge clk_i) begin
    cyc++;
    if (!rst_ni) mon_left = 0;
    else if (mon_left > 0) begin
      if (mon_left == 16) check("R2 fs one cycle", {63'd0, sdofs_o}, 64'd0);
      mon_sr = {mon_sr[14:0], sdo_o};
      mon_left--;
      if (mon_left == 0) begin
        out_q.push_back(mon_sr);
        stamp_q.push_back(mon_stamp);
      end
    end else if (sdofs_o) begin
      mon_left  = 16;
      mon_stamp = cyc;
    end
  end

  task automatic send_word(input logic [15:0] w);
    @(negedge clk_i) sdifs_i = 1'b1;
    for (int b = 15; b >= 0; b--) begin
      @(negedge clk_i);
      sdifs_i = 1'b0;
      sdi_i   = w[b];
    end
  endtask

  task automatic expect_out(input string req, input logic [15:0] exp, output int stamp);
    int n = 0;
    stamp = 0;
    while (out_q.size() == 0 && n < 60) begin
      @(negedge clk_i);
      n++;
    end
    if (out_q.size() == 0) begin
      check({req, " no frame"}, 64'd0, {48'd0, exp});
    end else begin
      check(req, {48'd0, out_q.pop_front()}, {48'd0, exp});
      stamp = stamp_q.pop_front();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] w, exp_w;
    int st1, st2, cnt, len, kind;
    void'($urandom(32'h0c0dec5));
    for (int i = 0; i < 8; i++) mregs[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 sdofs", {63'd0, sdofs_o}, 64'd0);
    check("R1 mode", {63'd0, data_mode_o}, 64'd0);
    check("R1 regs", ctrl_regs_o, 64'd0);
    check("R1 dac", {47'd0, dac_upd_o, dac_word_o}, 64'd0);

    // R3 local write to register 3
    send_word(16'h8000 | (16'd3 << 8) | 16'h00A5);
    @(negedge clk_i);
    mregs[3] = 8'hA5;
    check("R3 not forwarded", {63'd0, sdofs_o}, 64'd0);
    check("R3 reg write", ctrl_regs_o, model_regs());

    // R4 address decrement, R6 timing
    send_word(16'h8000 | (16'd2 << 11) | (16'd5 << 8) | 16'h003C);
    @(negedge clk_i);
    check("R6 fs after last bit", {63'd0, sdofs_o}, 64'd1);
    expect_out("R4 decremented", 16'h8000 | (16'd1 << 11) | (16'd5 << 8) | 16'h003C, st1);

    // R5 plain word unchanged
    send_word(16'h7ABC);
    @(negedge clk_i);
    check("R6 fs plain", {63'd0, sdofs_o}, 64'd1);
    expect_out("R5 plain forward", 16'h7ABC, st1);

    // R7 sample event
    @(negedge clk_i) begin sample_i = 1'b1; adc_word_i = 16'hC3A1; end
    @(negedge clk_i) sample_i = 1'b0;
    check("R7 fs after sample", {63'd0, sdofs_o}, 64'd1);
    expect_out("R7 adc word", 16'hC3A1, st1);

    // R8 sample and forward on the same edge
    fork
      send_word(16'h8000 | (16'd4 << 11) | 16'h0155);
      begin
        repeat (17) @(negedge clk_i);
        sample_i = 1'b1;
        adc_word_i = 16'h5A0F;
        @(negedge clk_i) sample_i = 1'b0;
      end
    join
    check("R8 fs at collision", {63'd0, sdofs_o}, 64'd1);
    expect_out("R8 adc first", 16'h5A0F, st1);
    expect_out("R8 forward second", 16'h8000 | (16'd3 << 11) | 16'h0155, st2);
    check("R8 fs spacing", 64'(st2 - st1), 64'd17);

    // random program-mode words
    for (int k = 0; k < 30; k++) begin
      w = 16'($urandom);
      kind = int'($urandom % 3);
      if (kind == 0) begin
        w[15] = 1'b1; w[13:11] = 3'd0; w[10:8] = 3'(1 + $urandom % 7);
      end else if (kind == 1) begin
        w[15] = 1'b1; w[13:11] = 3'(1 + $urandom % 7);
      end else begin
        w[15] = 1'b0;
      end
      send_word(w);
      @(negedge clk_i);
      if (kind == 0) begin
        mregs[w[10:8]] = w[7:0];
        check("R3 random no fs", {63'd0, sdofs_o}, 64'd0);
        check("R3 random write", ctrl_regs_o, model_regs());
      end else begin
        exp_w = w;
        if (kind == 1) exp_w[13:11] = w[13:11] - 3'd1;
        check("R6 random fs", {63'd0, sdofs_o}, 64'd1);
        expect_out(kind == 1 ? "R4 random" : "R5 random", exp_w, st1);
      end
    end

    // R9 enter data mode, chain length 3
    len = 3;
    send_word(16'h8000 | 16'h0082);
    @(negedge clk_i);
    mregs[0] = 8'h82;
    check("R9 mode set", {63'd0, data_mode_o}, 64'd1);
    check("R9 regs", ctrl_regs_o, model_regs());

    // R10 / R11 data mode
    cnt = 0;
    for (int k = 0; k < 14; k++) begin
      w = (k == 4) ? 16'h81FF : 16'($urandom);
      send_word(w);
      @(negedge clk_i);
      cnt++;
      if (cnt == len) begin
        cnt = 0;
        check("R10 no fs", {63'd0, sdofs_o}, 64'd0);
        check("R10 dac word", {48'd0, dac_word_o}, {48'd0, w});
        check("R10 upd pulse", {63'd0, dac_upd_o}, 64'd1);
        @(negedge clk_i);
        check("R10 upd one cycle", {63'd0, dac_upd_o}, 64'd0);
      end else begin
        check("R11 fs", {63'd0, sdofs_o}, 64'd1);
        expect_out("R11 forward", w, st1);
      end
    end
    check("R9 regs frozen", ctrl_regs_o, model_regs());
    check("R9 mode held", {63'd0, data_mode_o}, 64'd1);

    @(negedge clk_i) begin sample_i = 1'b1; adc_word_i = 16'h1234; end
    @(negedge clk_i) sample_i = 1'b0;
    expect_out("R7 sample data mode", 16'h1234, st1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule